// File: doc/BRIEF.md
# Per-Class Fill-PC Dead-Block Predictor

This block predicts, at the moment a block leaves a private mid-level cache, whether that block will be used again. Each block has already been sorted into a reuse class. The classes use codes 0 to 3, plus class 4 for blocks that have been seen to hit in the shared cache. Each of the classes 0 to 3 owns a small table. A table entry pairs the program counter of the load or store that brought a block in with a 3-bit saturating confidence counter. The counter rises when blocks brought in by that instruction are reused. It falls when such blocks leave without reuse. A counter that has reached zero marks the instruction's blocks as dead.

The surrounding cache controller drives up to three events per cycle, each carrying a class code and a program counter:
- a fill, when a block enters the cache;
- a reuse, when a resident block is hit again;
- an eviction query, with a flag telling whether the leaving block was reused while resident.

The predictor answers every eviction query with a registered dead or live verdict one cycle later. Class 4, and any code above 4, is always live and never touches a table. The verdict is a pure prediction. The state of the tables can only be seen through later verdicts.

Top module: `fill_pc_predictor`

## Requirements
- R1: `verdict_vld` is high in exactly the cycles that follow a cycle with `evict_vld` high. The verdict is computed from table state as it stood before that cycle's updates.
- R2: A query of class c (0 to 3) gives `verdict_dead` = 1 only when class c's table holds the queried PC with a counter of 0.
- R3: Class codes 4 to 7 always give a live verdict. Fill, reuse and eviction events with such codes change no table.
- R4: A query whose PC is not held in its class table gives a live verdict. After reset every table is empty.
- R5: A fill whose PC is not in its class table allocates an entry with counter 1. A fill whose PC is already present leaves that counter unchanged.
- R6: A reuse event whose PC is present increments the counter, saturating at 7. A reuse event that misses the table changes nothing.
- R7: A query with `evict_reused` = 0 that hits decrements the counter, saturating at 0. A query with `evict_reused` = 1 leaves the counter unchanged.
- R8: Allocation takes an empty entry while one exists, otherwise the entry least recently filled. A fill that hits counts as a use for this ordering.
- R9: A reuse and a decrementing query that hit the same entry in the same cycle cancel. An allocation that replaces an entry overrides any same-cycle count change on that entry.
- R10: Each class keeps its own table. The same PC in two classes has two independent counters.
- R11: While and right after reset, `verdict_vld` and `verdict_dead` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | Fill event valid |
| fill_cls | input | 3 | Reuse class of the filled block |
| fill_pc | input | 16 | Program counter that caused the fill |
| reuse_vld | input | 1 | Reuse event valid |
| reuse_cls | input | 3 | Reuse class of the reused block |
| reuse_pc | input | 16 | Fill program counter of the reused block |
| evict_vld | input | 1 | Eviction query valid |
| evict_cls | input | 3 | Reuse class of the leaving block |
| evict_pc | input | 16 | Fill program counter of the leaving block |
| evict_reused | input | 1 | Leaving block was reused while resident |
| verdict_vld | output | 1 | Verdict valid, one cycle after a query |
| verdict_dead | output | 1 | 1 = predicted dead, 0 = predicted live |

## Verification
The interesting overlap is a reuse event and a non-reused eviction query that land on the same table entry in one cycle. The increment and the decrement must cancel rather than one winning. The bench provokes this directly: it sets an entry to count 1, fires both events together, and expects a live verdict from that query, then a live verdict and a dead verdict from the next two queries. A constrained random phase over a pool of twelve PCs also lands fills, reuses and queries on the same class and entry together, including allocations that replace an entry being counted. Each verdict is judged against a bench model that applies all events of a cycle to the state before the edge.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    // Action applied to one table entry at the coming clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_DEC   = 2'd2,
        ACT_ALLOC = 2'd3
    } act_e;

endpackage

// File: rtl/fpp_lru.sv
// Fill-order age tracker for one table: age 0 is the newest, ENTRIES-1 the oldest.
module fpp_lru #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] age [ENTRIES];
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age[touch_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                age[i] <= IDX_W'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age[i] <= '0;
                end else if (age[i] < touched_age) begin
                    age[i] <= age[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age[i] == IDX_W'(ENTRIES - 1)) begin
                victim_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/fpp_table.sv
// One class's table of fill PCs with saturating confidence counters.
module fpp_table
    import fpp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 16,
    parameter int CNT_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_en,
    input  logic [PC_W-1:0] fill_pc,
    input  logic            reuse_en,
    input  logic [PC_W-1:0] reuse_pc,
    input  logic            dec_en,
    input  logic [PC_W-1:0] probe_pc,
    output logic            probe_dead
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_NEW = CNT_W'(1);

    logic [ENTRIES-1:0] ent_vld;
    logic [PC_W-1:0]    ent_tag [ENTRIES];
    logic [CNT_W-1:0]   ent_cnt [ENTRIES];

    logic [ENTRIES-1:0] fill_match, reuse_match, probe_match, zero_match;
    logic               fill_hit;
    logic [IDX_W-1:0]   fill_idx, victim_idx, touch_idx;
    act_e               act [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_match
        assign fill_match[i]  = ent_vld[i] && (ent_tag[i] == fill_pc);
        assign reuse_match[i] = ent_vld[i] && (ent_tag[i] == reuse_pc);
        assign probe_match[i] = ent_vld[i] && (ent_tag[i] == probe_pc);
        assign zero_match[i]  = probe_match[i] && (ent_cnt[i] == '0);
    end

    assign fill_hit   = |fill_match;
    assign probe_dead = |zero_match;

    always_comb begin
        fill_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i]) begin
                fill_idx = IDX_W'(i);
            end
        end
    end

    assign touch_idx = fill_hit ? fill_idx : victim_idx;

    fpp_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (fill_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic do_inc, do_dec;

        assign do_inc = reuse_en && reuse_match[i];
        assign do_dec = dec_en && probe_match[i];

        always_comb begin
            if (fill_en && !fill_hit && (victim_idx == IDX_W'(i))) begin
                act[i] = ACT_ALLOC;
            end else if (do_inc && !do_dec) begin
                act[i] = ACT_INC;
            end else if (do_dec && !do_inc) begin
                act[i] = ACT_DEC;
            end else begin
                act[i] = ACT_HOLD;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[i] <= 1'b0;
                ent_tag[i] <= '0;
                ent_cnt[i] <= '0;
            end else begin
                unique case (act[i])
                    ACT_ALLOC: begin
                        ent_vld[i] <= 1'b1;
                        ent_tag[i] <= fill_pc;
                        ent_cnt[i] <= CNT_NEW;
                    end
                    ACT_INC: begin
                        if (ent_cnt[i] != CNT_MAX) ent_cnt[i] <= ent_cnt[i] + 1'b1;
                    end
                    ACT_DEC: begin
                        if (ent_cnt[i] != '0) ent_cnt[i] <= ent_cnt[i] - 1'b1;
                    end
                    ACT_HOLD: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/fill_pc_predictor.sv
// Per-class fill-PC dead-block predictor: one table per class below NUM_TABLES.
module fill_pc_predictor #(
    parameter int PC_W       = 16,
    parameter int CLS_W      = 3,
    parameter int NUM_TABLES = 4,
    parameter int ENTRIES    = 8,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_vld,
    input  logic [CLS_W-1:0] fill_cls,
    input  logic [PC_W-1:0]  fill_pc,
    input  logic             reuse_vld,
    input  logic [CLS_W-1:0] reuse_cls,
    input  logic [PC_W-1:0]  reuse_pc,
    input  logic             evict_vld,
    input  logic [CLS_W-1:0] evict_cls,
    input  logic [PC_W-1:0]  evict_pc,
    input  logic             evict_reused,
    output logic             verdict_vld,
    output logic             verdict_dead
);

    logic [NUM_TABLES-1:0] tbl_dead;
    logic                  q_dead;

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
        fpp_table #(
            .ENTRIES (ENTRIES),
            .PC_W    (PC_W),
            .CNT_W   (CNT_W)
        ) u_tbl (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill_en    (fill_vld && (fill_cls == CLS_W'(t))),
            .fill_pc    (fill_pc),
            .reuse_en   (reuse_vld && (reuse_cls == CLS_W'(t))),
            .reuse_pc   (reuse_pc),
            .dec_en     (evict_vld && !evict_reused && (evict_cls == CLS_W'(t))),
            .probe_pc   (evict_pc),
            .probe_dead (tbl_dead[t])
        );
    end

    always_comb begin
        q_dead = 1'b0;
        for (int t = 0; t < NUM_TABLES; t++) begin
            if (evict_cls == CLS_W'(t)) begin
                q_dead = tbl_dead[t];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_vld  <= 1'b0;
            verdict_dead <= 1'b0;
        end else begin
            verdict_vld  <= evict_vld;
            verdict_dead <= evict_vld && q_dead;
        end
    end

endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
    parameter int CLS_W      = 3,
    parameter int NUM_TABLES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fill_vld,
    input logic [CLS_W-1:0] fill_cls,
    input logic             evict_vld,
    input logic [CLS_W-1:0] evict_cls,
    input logic             verdict_vld,
    input logic             verdict_dead
);

    logic seen_fill;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_fill <= 1'b0;
        end else if (fill_vld && (fill_cls < CLS_W'(NUM_TABLES))) begin
            seen_fill <= 1'b1;
        end
    end

    p_verdict_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld |=> verdict_vld);

    p_no_stray_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_vld |=> !verdict_vld);

    p_dead_is_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_dead |-> verdict_vld);

    p_upper_class_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_vld && (evict_cls >= CLS_W'(NUM_TABLES))) |=> !verdict_dead);

    p_empty_means_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_dead |-> seen_fill);

endmodule

bind fill_pc_predictor fpp_checker #(
    .CLS_W      (CLS_W),
    .NUM_TABLES (NUM_TABLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_vld     (fill_vld),
    .fill_cls     (fill_cls),
    .evict_vld    (evict_vld),
    .evict_cls    (evict_cls),
    .verdict_vld  (verdict_vld),
    .verdict_dead (verdict_dead)
);

// File: tb/fill_pc_predictor_test.sv
module fill_pc_predictor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_vld = 1'b0, reuse_vld = 1'b0, evict_vld = 1'b0, evict_reused = 1'b0;
    logic [2:0]  fill_cls = '0, reuse_cls = '0, evict_cls = '0;
    logic [15:0] fill_pc = '0, reuse_pc = '0, evict_pc = '0;
    logic        verdict_vld, verdict_dead;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model: 4 class tables of 8 entries
    bit          m_v [4][8];
    logic [15:0] m_t [4][8];
    int          m_c [4][8];
    int          m_a [4][8];

    fill_pc_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .fill_vld(fill_vld), .fill_cls(fill_cls), .fill_pc(fill_pc),
        .reuse_vld(reuse_vld), .reuse_cls(reuse_cls), .reuse_pc(reuse_pc),
        .evict_vld(evict_vld), .evict_cls(evict_cls), .evict_pc(evict_pc),
        .evict_reused(evict_reused),
        .verdict_vld(verdict_vld), .verdict_dead(verdict_dead)
    );

    always #10 clk = ~clk;

    function automatic int find(input int c, input logic [15:0] pc);
        find = -1;
        if (c < 4) begin
            for (int i = 0; i < 8; i++) if (m_v[c][i] && m_t[c][i] == pc) find = i;
        end
    endfunction

    function automatic int oldest(input int c);
        oldest = 0;
        for (int i = 0; i < 8; i++) if (m_a[c][i] == 7) oldest = i;
    endfunction

    task automatic check(input string req, input bit gv, input bit gd, input bit ev, input bit ed);
        total++;
        if (gv !== ev || gd !== ed) begin
            bad++;
            $display("FAIL %s: vld/dead got %0b/%0b expected %0b/%0b", req, gv, gd, ev, ed);
        end
    endtask

    // One cycle: drive, predict from pre-edge model, update model, check after the edge.
    task automatic step(input bit fv, input int fc, input logic [15:0] fp,
                        input bit rv, input int rc, input logic [15:0] rp,
                        input bit ev, input int ec, input logic [15:0] ep, input bit er,
                        input string req);
        int fh, vi, ri, di, tc, old;
        bit exp_dead;
        fill_vld = fv; fill_cls = 3'(fc); fill_pc = fp;
        reuse_vld = rv; reuse_cls = 3'(rc); reuse_pc = rp;
        evict_vld = ev; evict_cls = 3'(ec); evict_pc = ep; evict_reused = er;
        fh = find(fc, fp);
        vi = (fc < 4) ? oldest(fc) : 0;
        ri = find(rc, rp);
        di = find(ec, ep);
        exp_dead = ev && (di >= 0) && (m_c[ec][di] == 0);
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 8; i++) begin
                bit inc, dec;
                inc = rv && rc == c && ri == i;
                dec = ev && !er && ec == c && di == i;
                if (inc && !dec && m_c[c][i] < 7) m_c[c][i]++;
                if (dec && !inc && m_c[c][i] > 0) m_c[c][i]--;
            end
        end
        if (fv && fc < 4) begin
            if (fh < 0) begin
                m_v[fc][vi] = 1; m_t[fc][vi] = fp; m_c[fc][vi] = 1; tc = vi;
            end else begin
                tc = fh;
            end
            old = m_a[fc][tc];
            for (int i = 0; i < 8; i++) begin
                if (i == tc) m_a[fc][i] = 0;
                else if (m_a[fc][i] < old) m_a[fc][i]++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(req, verdict_vld, verdict_dead, ev, exp_dead);
    endtask

    task automatic fill(input int c, input logic [15:0] pc, input string req);
        step(1, c, pc, 0, 0, 0, 0, 0, 0, 0, req);
    endtask
    task automatic reuse(input int c, input logic [15:0] pc, input string req);
        step(0, 0, 0, 1, c, pc, 0, 0, 0, 0, req);
    endtask
    task automatic query(input int c, input logic [15:0] pc, input bit er, input string req);
        step(0, 0, 0, 0, 0, 0, 1, c, pc, er, req);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 8; i++) begin
                m_v[c][i] = 0; m_t[c][i] = '0; m_c[c][i] = 0; m_a[c][i] = i;
            end
        repeat (4) @(negedge clk);
        check("R11", verdict_vld, verdict_dead, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", verdict_vld, verdict_dead, 0, 0);

        // R4: empty table gives live
        query(0, 16'h0AAA, 0, "R4");
        // R5/R7/R2: allocate at 1, decrement to 0, then dead
        fill(0, 16'h0AAA, "R5");
        query(0, 16'h0AAA, 0, "R7");
        query(0, 16'h0AAA, 0, "R2");
        query(0, 16'h0AAA, 1, "R7");
        query(0, 16'h0AAA, 1, "R7");
        // R10: same PC in another class is independent
        query(2, 16'h0AAA, 0, "R10");
        // R6: saturation at 7
        fill(1, 16'h0BBB, "R6");
        for (int k = 0; k < 8; k++) reuse(1, 16'h0BBB, "R6");
        for (int k = 0; k < 7; k++) query(1, 16'h0BBB, 0, "R6");
        query(1, 16'h0BBB, 0, "R6");
        reuse(1, 16'h0CCC, "R6");
        query(1, 16'h0BBB, 0, "R6");
        // R3: upper class codes touch nothing and are live
        fill(4, 16'h0DDD, "R3");
        reuse(4, 16'h0DDD, "R3");
        query(4, 16'h0DDD, 0, "R3");
        fill(3, 16'h0DDD, "R3");
        query(4, 16'h0DDD, 0, "R3");
        query(5, 16'h0DDD, 0, "R3");
        query(3, 16'h0DDD, 0, "R3");
        query(3, 16'h0DDD, 0, "R3");
        // R9: reuse and decrement on the same entry cancel
        fill(2, 16'h0EEE, "R9");
        step(0, 0, 0, 1, 2, 16'h0EEE, 1, 2, 16'h0EEE, 0, "R9");
        query(2, 16'h0EEE, 0, "R9");
        query(2, 16'h0EEE, 0, "R9");
        // R5: fill hit keeps counter at 0
        fill(2, 16'h0EEE, "R5");
        query(2, 16'h0EEE, 1, "R5");
        // R8: oldest entry replaced once the table is full
        for (int k = 0; k < 8; k++) fill(3, 16'h3000 + 16'(k), "R8");
        query(3, 16'h0DDD, 1, "R8");
        // R8: a fill hit refreshes the entry so it survives
        for (int k = 0; k < 7; k++) fill(0, 16'h4000 + 16'(k), "R8");
        fill(0, 16'h0AAA, "R8");
        fill(0, 16'h4100, "R8");
        query(0, 16'h0AAA, 1, "R8");

        // constrained random mix with pooled PCs
        for (int n = 0; n < 4000; n++) begin
            step($urandom_range(0, 1), $urandom_range(0, 5), 16'h1000 + 16'($urandom_range(0, 11)),
                 $urandom_range(0, 1), $urandom_range(0, 5), 16'h1000 + 16'($urandom_range(0, 11)),
                 $urandom_range(0, 1), $urandom_range(0, 5), 16'h1000 + 16'($urandom_range(0, 11)),
                 ($urandom_range(0, 9) < 3), "R2");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule